// File: doc/BRIEF.md
# Four-Channel Serial Controller Register Bank

This block is the register front end of a four-channel serial controller. It decodes a 16 KiB address window: the lowest 256-byte page holds global registers (pending-event status, per-channel TX/RX enable mask, a channel command register and a command response register). Each channel then owns its own 256-byte page holding its transmit and receive ring boundaries. The DMA engines read the ring pointers, the enable bits and the channel on/off state from plain output pins. They report finished transfers as single-cycle event pulses, and the block folds these pulses into a level interrupt.

Register access uses a valid/ready request channel and a valid/ready read-response channel. A request is taken on a rising clock edge when `req_valid_i` and `req_ready_o` are both high. Writes take effect at that edge and produce no response. A read produces one response beat on the following cycle, and the beat stays valid and unchanged until `rsp_ready_i` is high. While a response is waiting and `rsp_ready_i` is low, `req_ready_o` is low. A strap input `mode_i` picks which command opcodes switch a channel off.

Top module: `serial_regbank`

## Requirements
- R1: Channel n (0..3) owns the page starting at byte address 0x100·(n+1). Inside that page, offset 0x80 is TX ring start, 0x84 is TX ring end, 0x88 is RX ring start and 0x8C is RX ring end. Each reads back the last value written and is driven on the matching `*_o` bus slice [32n+31:32n].
- R2: A write to a ring start register also loads that ring's current pointer (`tx_cur_o` / `rx_cur_o`) with the written value. A write to a ring end register leaves the current pointer unchanged.
- R3: The enable mask at global offset 0x14 keeps 2 bits per channel. Bit 2n is channel n TX enable (`tx_en_o[n]`) and bit 2n+1 is channel n RX enable (`rx_en_o[n]`). Bits 8 and above read back as zero.
- R4: Reading global offset 0x00 returns bit n set for a pending TX event on channel n, and bit 4+n set for a pending RX event on channel n. A pending event is shown only while that channel's matching enable bit is set. Pending events stay stored while hidden.
- R5: A pulse on `tx_evt_i[n]` or `rx_evt_i[n]` marks that event pending from the next cycle. Any write to offset 0x00 clears every pending event. An event pulse in the same cycle as the clear write stays pending.
- R6: `irq_o` is high exactly when the status register read at offset 0x00 would be nonzero.
- R7: A write to the command register (offset 0x20) takes the opcode from bits [19:12] and the channel from bits [1:0]. Opcode 0x00 sets `chan_on_o` for that channel.
- R8: With `mode_i`=0, opcode 0x10 clears `chan_on_o` for the addressed channel. With `mode_i`=1, opcodes 0x30 and 0x50 clear it. Any other opcode, including the other mode's off codes, leaves `chan_on_o` unchanged.
- R9: The command response register (offset 0x24) always reads 0x0000FFFF. The command register reads as zero.
- R10: After reset every register, pending event and output is zero. Unmapped offsets read as zero, and writes to them change nothing.
- R11: A read response stays valid with stable data until `rsp_ready_i` is high, and `req_ready_o` is low for as long as a response is waiting unaccepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Command opcode set select strap |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 14 | Byte address within the window |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response consumed |
| rsp_rdata_o | output | 32 | Read response data |
| tx_evt_i | input | 4 | Per-channel TX completion pulse |
| rx_evt_i | input | 4 | Per-channel RX completion pulse |
| chan_on_o | output | 4 | Per-channel on state set by commands |
| tx_en_o | output | 4 | Per-channel TX enable from the mask |
| rx_en_o | output | 4 | Per-channel RX enable from the mask |
| tx_start_o | output | 128 | TX ring start, 32 bits per channel |
| tx_end_o | output | 128 | TX ring end, 32 bits per channel |
| tx_cur_o | output | 128 | TX current descriptor pointer, 32 bits per channel |
| rx_start_o | output | 128 | RX ring start, 32 bits per channel |
| rx_end_o | output | 128 | RX ring end, 32 bits per channel |
| rx_cur_o | output | 128 | RX current descriptor pointer, 32 bits per channel |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench writes a distinct value into every pointer of every channel, so a page or offset decode that aliases two registers shows up as a wrong read-back. Events are raised on all channels while the enable mask is set to an asymmetric value (TX enabled on the upper two channels, RX on the lower two). This separates a status bit that is gated by the wrong enable bit, or placed at the wrong position, from a correct one. A clear write that coincides with an event pulse shows whether the clear wins over the new event. Commands are issued in both strap modes with each mode's own off codes and with the other mode's off codes, so a mode-blind decoder is caught.

// File: rtl/srb_pkg.sv
package srb_pkg;
  // Offsets inside a channel page
  localparam logic [7:0] OFS_TX_START = 8'h80;
  localparam logic [7:0] OFS_TX_END   = 8'h84;
  localparam logic [7:0] OFS_RX_START = 8'h88;
  localparam logic [7:0] OFS_RX_END   = 8'h8C;

  // Command opcodes
  typedef enum logic [7:0] {
    OP_CHAN_ON    = 8'h00,
    OP_OFF_MODE0  = 8'h10,
    OP_OFF_MODE1A = 8'h30,
    OP_OFF_MODE1B = 8'h50
  } cmd_op_e;

  localparam int unsigned OP_LSB = 12;
  localparam int unsigned OP_W   = 8;
endpackage

// File: rtl/srb_bus_port.sv
module srb_bus_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] rd_data,
  input  logic          rsp_ready,
  output logic          req_ready,
  output logic          acc_wr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic acc;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign acc_wr    = acc && req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)))
    else $error("response dropped or changed while stalled"); // R11

  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready)
    else $error("request accepted while response pending"); // R11
endmodule

// File: rtl/srb_chan_regs.sv
module srb_chan_regs
  import srb_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] tx_start,
  output logic [DW-1:0] tx_end,
  output logic [DW-1:0] tx_cur,
  output logic [DW-1:0] rx_start,
  output logic [DW-1:0] rx_end,
  output logic [DW-1:0] rx_cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_start <= '0;
      tx_end   <= '0;
      tx_cur   <= '0;
      rx_start <= '0;
      rx_end   <= '0;
      rx_cur   <= '0;
    end else if (wr_en) begin
      unique case (off)
        OFS_TX_START: begin
          tx_start <= wdata;
          tx_cur   <= wdata;
        end
        OFS_TX_END:   tx_end <= wdata;
        OFS_RX_START: begin
          rx_start <= wdata;
          rx_cur   <= wdata;
        end
        OFS_RX_END:   rx_end <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (off)
      OFS_TX_START: rd_data = tx_start;
      OFS_TX_END:   rd_data = tx_end;
      OFS_RX_START: rd_data = rx_start;
      OFS_RX_END:   rd_data = rx_end;
      default:      rd_data = '0;
    endcase
  end

  AST_TX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFS_TX_START) |=> (tx_cur == tx_start))
    else $error("tx current not reloaded"); // R2

  AST_RX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFS_RX_START) |=> (rx_cur == rx_start))
    else $error("rx current not reloaded"); // R2

  AST_END_KEEPS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (off == OFS_TX_END || off == OFS_RX_END)) |=> ($stable(tx_cur) && $stable(rx_cur)))
    else $error("end write moved a current pointer"); // R2
endmodule

// File: rtl/srb_cmd_dec.sv
module srb_cmd_dec
  import srb_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode,
  input  logic            cmd_we,
  input  logic [OP_W-1:0] op,
  input  logic [CH_W-1:0] ch,
  output logic [NCH-1:0]  chan_on
);
  logic is_on;
  logic is_off;

  assign is_on  = (op == OP_CHAN_ON);
  assign is_off = mode ? (op == OP_OFF_MODE1A || op == OP_OFF_MODE1B)
                       : (op == OP_OFF_MODE0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_on <= '0;
    end else if (cmd_we) begin
      if (is_on)       chan_on[ch] <= 1'b1;
      else if (is_off) chan_on[ch] <= 1'b0;
    end
  end

  AST_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == 8'h00) |=> chan_on[$past(ch)])
    else $error("enable command ignored"); // R7

  AST_UNKNOWN_OP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op != 8'h00 && op != 8'h10 && op != 8'h30 && op != 8'h50) |=> $stable(chan_on))
    else $error("unknown opcode changed state"); // R8

  AST_FOREIGN_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && mode && op == 8'h10) |=> $stable(chan_on))
    else $error("mode0 off code acted in mode1"); // R8
endmodule

// File: rtl/srb_evt_stat.sv
module srb_evt_stat #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [NCH-1:0] tx_evt,
  input  logic [NCH-1:0] rx_evt,
  input  logic [NCH-1:0] tx_en,
  input  logic [NCH-1:0] rx_en,
  output logic [NCH-1:0] stat_tx,
  output logic [NCH-1:0] stat_rx,
  output logic           irq
);
  logic [NCH-1:0] pend_tx;
  logic [NCH-1:0] pend_rx;

  // New events win over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_tx <= '0;
      pend_rx <= '0;
    end else begin
      pend_tx <= (clr ? '0 : pend_tx) | tx_evt;
      pend_rx <= (clr ? '0 : pend_rx) | rx_evt;
    end
  end

  assign stat_tx = pend_tx & tx_en;
  assign stat_rx = pend_rx & rx_en;
  assign irq     = |{stat_rx, stat_tx};

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt != '0 || rx_evt != '0) |=>
      (((pend_tx & $past(tx_evt)) == $past(tx_evt)) && ((pend_rx & $past(rx_evt)) == $past(rx_evt))))
    else $error("event pulse lost"); // R5

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && tx_evt == '0 && rx_evt == '0) |=> (pend_tx == '0 && pend_rx == '0))
    else $error("clear left pending events"); // R5

  AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_tx != '0) || (pend_rx != '0)))
    else $error("irq without pending event"); // R6
endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
  import srb_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 14,
  parameter logic [7:0]  STAT_OFS = 8'h00,
  parameter logic [7:0]  MASK_OFS = 8'h14,
  parameter logic [7:0]  CMD_OFS  = 8'h20,
  parameter logic [7:0]  RSP_OFS  = 8'h24,
  parameter logic [DW-1:0] RSP_VAL = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DW-1:0]     rsp_rdata_o,
  input  logic [NCH-1:0]    tx_evt_i,
  input  logic [NCH-1:0]    rx_evt_i,
  output logic [NCH-1:0]    chan_on_o,
  output logic [NCH-1:0]    tx_en_o,
  output logic [NCH-1:0]    rx_en_o,
  output logic [NCH*DW-1:0] tx_start_o,
  output logic [NCH*DW-1:0] tx_end_o,
  output logic [NCH*DW-1:0] tx_cur_o,
  output logic [NCH*DW-1:0] rx_start_o,
  output logic [NCH*DW-1:0] rx_end_o,
  output logic [NCH*DW-1:0] rx_cur_o,
  output logic              irq_o
);
  localparam int unsigned PG_W   = AW - 8;
  localparam int unsigned MASK_W = 2 * NCH;
  localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1;

  logic [PG_W-1:0] page;
  logic [7:0]      lo;
  logic            glob;
  logic            acc_wr;
  logic [DW-1:0]   rd_data;
  logic            stat_clr;
  logic            mask_we;
  logic            cmd_we;
  logic [MASK_W-1:0] mask_q;
  logic [NCH-1:0]  stat_tx;
  logic [NCH-1:0]  stat_rx;
  logic [NCH-1:0]  ch_sel;
  logic [DW-1:0]   ch_rd [NCH];

  assign page = req_addr_i[AW-1:8];
  assign lo   = req_addr_i[7:0];
  assign glob = (page == '0);

  srb_bus_port #(.DW(DW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid_i),
    .req_write (req_write_i),
    .rd_data   (rd_data),
    .rsp_ready (rsp_ready_i),
    .req_ready (req_ready_o),
    .acc_wr    (acc_wr),
    .rsp_valid (rsp_valid_o),
    .rsp_rdata (rsp_rdata_o)
  );

  assign stat_clr = acc_wr && glob && (lo == STAT_OFS);
  assign mask_we  = acc_wr && glob && (lo == MASK_OFS);
  assign cmd_we   = acc_wr && glob && (lo == CMD_OFS);

  // Enable mask: two bits per channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= req_wdata_i[MASK_W-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_en
    assign tx_en_o[g] = mask_q[2*g];
    assign rx_en_o[g] = mask_q[2*g+1];
  end

  srb_evt_stat #(.NCH(NCH)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (stat_clr),
    .tx_evt  (tx_evt_i),
    .rx_evt  (rx_evt_i),
    .tx_en   (tx_en_o),
    .rx_en   (rx_en_o),
    .stat_tx (stat_tx),
    .stat_rx (stat_rx),
    .irq     (irq_o)
  );

  srb_cmd_dec #(.NCH(NCH)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_i),
    .cmd_we  (cmd_we),
    .op      (req_wdata_i[OP_LSB +: OP_W]),
    .ch      (req_wdata_i[CH_W-1:0]),
    .chan_on (chan_on_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_sel[g] = (page == PG_W'(g + 1));

    srb_chan_regs #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (acc_wr && ch_sel[g]),
      .off      (lo),
      .wdata    (req_wdata_i),
      .rd_data  (ch_rd[g]),
      .tx_start (tx_start_o[g*DW +: DW]),
      .tx_end   (tx_end_o[g*DW +: DW]),
      .tx_cur   (tx_cur_o[g*DW +: DW]),
      .rx_start (rx_start_o[g*DW +: DW]),
      .rx_end   (rx_end_o[g*DW +: DW]),
      .rx_cur   (rx_cur_o[g*DW +: DW])
    );
  end

  // Read data mux
  always_comb begin
    rd_data = '0;
    if (glob) begin
      if (lo == STAT_OFS)      rd_data = DW'({stat_rx, stat_tx});
      else if (lo == MASK_OFS) rd_data = DW'(mask_q);
      else if (lo == RSP_OFS)  rd_data = RSP_VAL;
    end
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel[i]) rd_data = ch_rd[i];
    end
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((tx_en_o | rx_en_o) != '0))
    else $error("irq with all enables off"); // R4

  AST_UNMAPPED_WR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && glob && lo != STAT_OFS && lo != MASK_OFS && lo != CMD_OFS)
      |=> ($stable(chan_on_o) && $stable(tx_en_o) && $stable(rx_en_o)))
    else $error("unmapped write changed state"); // R10
endmodule

// File: tb/tb_serial_regbank.sv
`timescale 1ns/100ps
module tb_serial_regbank;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic [NCH-1:0] tx_evt = '0;
  logic [NCH-1:0] rx_evt = '0;
  logic [NCH-1:0] chan_on, tx_en, rx_en;
  logic [NCH*DW-1:0] tx_start, tx_end, tx_cur, rx_start, rx_end, rx_cur;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  serial_regbank dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
    .chan_on_o(chan_on), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .tx_start_o(tx_start), .tx_end_o(tx_end), .tx_cur_o(tx_cur),
    .rx_start_o(rx_start), .rx_end_o(rx_end), .rx_cur_o(rx_cur),
    .irq_o(irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    do_req(1'b1, a, d);
  endtask

  // Driver side of the scoreboard: expected value queued before the read
  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    do_req(1'b0, a, '0);
  endtask

  task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] r);
    @(negedge clk);
    tx_evt = t; rx_evt = r;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0;
  endtask

  // Monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R11 unexpected response actual=0x%0h expected=none", rsp_rdata);
        end else begin
          check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  function automatic logic [AW-1:0] chan_addr(input int n, input logic [7:0] off);
    return AW'((n + 1) * 'h100 + off);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 reset chan_on", DW'(chan_on), 0);
    check("R10 reset tx_en", DW'(tx_en), 0);
    check("R10 reset irq", DW'(irq), 0);
    check("R10 reset tx_cur ch3", tx_cur[3*DW +: DW], 0);
    rd(14'h000, 0, "R10 reset status");
    rd(14'h014, 0, "R10 reset mask");
    rd(chan_addr(2, 8'h88), 0, "R10 reset rx start");

    // R1 / R2 pointer registers
    for (int n = 0; n < NCH; n++) begin
      wr(chan_addr(n, 8'h80), 32'h1000_0010 + n * 'h100);
      check("R2 tx start reloads tx_cur", tx_cur[n*DW +: DW], 32'h1000_0010 + n * 'h100);
      wr(chan_addr(n, 8'h84), 32'h1000_0080 + n * 'h100);
      check("R2 tx end keeps tx_cur", tx_cur[n*DW +: DW], 32'h1000_0010 + n * 'h100);
      wr(chan_addr(n, 8'h88), 32'h2000_0010 + n * 'h100);
      check("R2 rx start reloads rx_cur", rx_cur[n*DW +: DW], 32'h2000_0010 + n * 'h100);
      wr(chan_addr(n, 8'h8C), 32'h2000_0080 + n * 'h100);
      check("R2 rx end keeps rx_cur", rx_cur[n*DW +: DW], 32'h2000_0010 + n * 'h100);
    end
    for (int n = 0; n < NCH; n++) begin
      rd(chan_addr(n, 8'h80), 32'h1000_0010 + n * 'h100, "R1 tx start readback");
      rd(chan_addr(n, 8'h84), 32'h1000_0080 + n * 'h100, "R1 tx end readback");
      rd(chan_addr(n, 8'h88), 32'h2000_0010 + n * 'h100, "R1 rx start readback");
      rd(chan_addr(n, 8'h8C), 32'h2000_0080 + n * 'h100, "R1 rx end readback");
      check("R1 tx_end_o slice", tx_end[n*DW +: DW], 32'h1000_0080 + n * 'h100);
      check("R1 rx_start_o slice", rx_start[n*DW +: DW], 32'h2000_0010 + n * 'h100);
    end

    // R10 unmapped offsets
    wr(chan_addr(1, 8'h90), 32'hDEAD_BEEF);
    rd(chan_addr(1, 8'h90), 0, "R10 unmapped in channel page");
    rd(chan_addr(1, 8'h80), 32'h1000_0110, "R10 unmapped write left tx start");
    wr(14'h010, 32'hFFFF_FFFF);
    rd(14'h010, 0, "R10 unmapped global");
    rd(14'h500, 0, "R10 beyond last channel");
    check("R10 unmapped write left enables", DW'({tx_en, rx_en}), 0);

    // R3 enable mask
    wr(14'h014, 32'hFFFF_FF5A);
    rd(14'h014, 32'h0000_005A, "R3 mask readback upper bits zero");
    check("R3 tx_en_o", DW'(tx_en), 32'hC);
    check("R3 rx_en_o", DW'(rx_en), 32'h3);

    // R4 / R6 status gating
    check("R6 irq idle", DW'(irq), 0);
    pulse(4'hF, 4'hF);
    rd(14'h000, 32'h3C, "R4 status gated by enables");
    check("R6 irq with reported event", DW'(irq), 1);
    wr(14'h014, 32'h0);
    rd(14'h000, 0, "R4 status hidden when disabled");
    check("R6 irq low when hidden", DW'(irq), 0);
    wr(14'h014, 32'hFF);
    rd(14'h000, 32'hFF, "R4 hidden events still pending");

    // R5 clear with coincident event
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 14'h000; req_wdata = 32'h0;
    tx_evt = 4'b0001;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tx_evt = '0;
    rd(14'h000, 32'h01, "R5 event during clear survives");
    wr(14'h000, 32'h1234);
    rd(14'h000, 0, "R5 write clears all");
    check("R6 irq after clear", DW'(irq), 0);
    pulse(4'h0, 4'b1000);
    rd(14'h000, 32'h80, "R4 rx bit position ch3");
    check("R6 irq rx only", DW'(irq), 1);
    wr(14'h000, 0);

    // R7 / R8 commands, mode 0
    mode = 1'b0;
    wr(14'h020, 32'h0000_0002);
    check("R7 enable ch2", DW'(chan_on), 32'h4);
    wr(14'h020, 32'h0000_0000);
    check("R7 enable ch0", DW'(chan_on), 32'h5);
    wr(14'h020, 32'h0001_0002);
    check("R8 mode0 off ch2", DW'(chan_on), 32'h1);
    wr(14'h020, 32'h0003_0000);
    check("R8 mode0 ignores 0x30", DW'(chan_on), 32'h1);
    wr(14'h020, 32'h0005_0000);
    check("R8 mode0 ignores 0x50", DW'(chan_on), 32'h1);
    rd(14'h020, 0, "R9 command reads zero");
    rd(14'h024, 32'h0000_FFFF, "R9 response value");

    // mode 1
    mode = 1'b1;
    wr(14'h020, 32'h0001_0000);
    check("R8 mode1 ignores 0x10", DW'(chan_on), 32'h1);
    wr(14'h020, 32'h0005_0000);
    check("R8 mode1 off 0x50", DW'(chan_on), 32'h0);
    wr(14'h020, 32'h0000_0007);
    check("R7 channel from low two bits", DW'(chan_on), 32'h8);
    wr(14'h020, 32'h0002_0003);
    check("R8 mode1 ignores 0x20", DW'(chan_on), 32'h8);
    wr(14'h020, 32'h0003_0003);
    check("R8 mode1 off 0x30", DW'(chan_on), 32'h0);

    // R11 back-pressure on the response
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(14'h024, 32'h0000_FFFF, "R11 stalled response data");
    check("R11 rsp held valid", DW'(rsp_valid), 1);
    check("R11 req_ready low while stalled", DW'(req_ready), 0);
    @(negedge clk);
    check("R11 still valid next cycle", DW'(rsp_valid), 1);
    check("R11 data stable", rsp_rdata, 32'h0000_FFFF);
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 response retired", DW'(rsp_valid), 0);
    check("R11 all responses seen", DW'(exp_q.size()), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule